// File: doc/BRIEF.md
# Low-Power-Aware Watchdog Timer

This block guards a system against stalled or runaway software. Once software turns it on, it must periodically write a two-word key sequence to a service register. Each valid sequence reloads a 6-bit down-counter from a programmable timeout. The counter steps down on a slow time base of about 2 Hz, which arrives as a one-cycle enable pulse in the system clock domain. If a step is due while the counter is already zero, the counter underflows and the block drives a reset pulse of fixed length.

The control word holds the enable bit, three freeze bits and the timeout. The whole word is write-once: the first write after reset locks it until the next reset. Each freeze bit suspends counting while the CPU is in the matching condition. Stop and doze are decoded from a 2-bit low-power mode code, and debug is a separate active-high flag. At the end of its reset pulse, the block has returned every field and lock to its power-up value.

Top module: `wdog_timer`

## Requirements
- R1: After reset the reset output is low and the control word reads 0x3F00. Bit 0 is enable, bit 1 is stop-freeze, bit 2 is doze-freeze, bit 3 is debug-freeze and bits 13:8 are the timeout; every other bit reads 0.
- R2: While the enable bit is 0, no number of ticks produces a reset pulse.
- R3: With the counter enabled and reloaded with timeout T, the (T+1)-th unserviced counting tick underflows it, and the reset output is high in the cycle after that tick. After only T ticks it stays low.
- R4: Each underflow produces a reset pulse that is high for exactly RST_CYCLES (default 4) system clocks.
- R5: The first write to the control word (address 0) sets bits 0 to 3 and the timeout. Any later control write is ignored until the next reset, as seen on the readback.
- R6: By the time the reset pulse ends, the control word reads 0x3F00 again and accepts a new first write.
- R7: A write of 0x5555 followed by a write of 0xAAAA to the service register (address 1) reloads the counter from the timeout.
- R8: Any other value written to the service register cancels a pending 0x5555. A following 0xAAAA then does not reload the counter.
- R9: When the mode code is 2'b10 (doze) and doze-freeze is set, ticks do not move the counter.
- R10: When the mode code is 2'b11 (stop) and stop-freeze is set, ticks do not move the counter.
- R11: When the debug flag is high and debug-freeze is set, ticks do not move the counter.
- R12: Mode code 2'b00 (run), mode code 2'b01 (wait), and doze or stop with its freeze bit clear all leave counting active.
- R13: Reading the service register returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle time-base pulse, about 2 Hz |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | 0 selects the control word, 1 selects the service register |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for the selected register (combinational) |
| lpm_i | input | 2 | CPU low-power mode code: 00 run, 01 wait, 10 doze, 11 stop |
| debug_i | input | 1 | CPU debug-mode flag, active high |
| wdog_rst_o | output | 1 | Watchdog reset pulse |

## Verification
The countdown is driven with several kinds of tick stream:
- Ticks with the enable bit still unwritten, which separates the idle state from counting.
- Ticks after a clean key sequence, which pins the exact tick on which underflow happens.
- Ticks after a broken sequence (0x5555, a stray value, then 0xAAAA), which shows whether that sequence wrongly reloaded the counter.
- Ticks under each low-power mode code and the debug flag, with the matching freeze bit set and with it clear, which separates a real freeze from a freeze decoded for the wrong mode.

A behavioural model in the bench predicts the reset output and the readback on every clock. Repeated control writes and a reset pulse in the middle of the run show whether the write-once locks are released at the right time.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned BIT_EN = 0;
  localparam int unsigned BIT_STOP = 1;
  localparam int unsigned BIT_DOZE = 2;
  localparam int unsigned BIT_DBG = 3;
  localparam int unsigned TOUT_LSB = 8;

  localparam logic [DATA_W-1:0] KEY_ARM = 16'h5555;
  localparam logic [DATA_W-1:0] KEY_FIRE = 16'hAAAA;

  typedef enum logic [1:0] {
    LPM_RUN  = 2'b00,
    LPM_WAIT = 2'b01,
    LPM_DOZE = 2'b10,
    LPM_STOP = 2'b11
  } lpm_e;

  typedef enum logic {
    ADDR_CTRL = 1'b0,
    ADDR_SVC  = 1'b1
  } reg_addr_e;

  typedef struct packed {
    logic en;
    logic stop_frz;
    logic doze_frz;
    logic dbg_frz;
  } ctrl_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int unsigned CW = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              we_i,
  input  reg_addr_e         addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output ctrl_t             ctrl_o,
  output logic [CW-1:0]     tout_o,
  output logic              svc_o
);
  ctrl_t         ctrl_q;
  logic [CW-1:0] tout_q;
  logic          lock_q;
  logic          armed_q;

  logic wr_ctrl, wr_svc;
  assign wr_ctrl = we_i && (addr_i == ADDR_CTRL);
  assign wr_svc  = we_i && (addr_i == ADDR_SVC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      tout_q  <= '1;
      lock_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (clr_i) begin
      ctrl_q  <= '0;
      tout_q  <= '1;
      lock_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (wr_ctrl && !lock_q) begin
        ctrl_q.en       <= wdata_i[BIT_EN];
        ctrl_q.stop_frz <= wdata_i[BIT_STOP];
        ctrl_q.doze_frz <= wdata_i[BIT_DOZE];
        ctrl_q.dbg_frz  <= wdata_i[BIT_DBG];
        tout_q          <= wdata_i[TOUT_LSB +: CW];
        lock_q          <= 1'b1;
      end
      if (wr_svc) armed_q <= (wdata_i == KEY_ARM);
    end
  end

  assign svc_o  = wr_svc && armed_q && (wdata_i == KEY_FIRE) && !clr_i;
  assign ctrl_o = ctrl_q;
  assign tout_o = tout_q;

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_CTRL) begin
      rdata_o[BIT_EN]           = ctrl_q.en;
      rdata_o[BIT_STOP]         = ctrl_q.stop_frz;
      rdata_o[BIT_DOZE]         = ctrl_q.doze_frz;
      rdata_o[BIT_DBG]          = ctrl_q.dbg_frz;
      rdata_o[TOUT_LSB +: CW]   = tout_q;
    end
  end

  // write-once lock holds the whole word
  p_lock_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q && !clr_i |=> $stable(ctrl_q) && $stable(tout_q));

  p_clr_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !lock_q && !ctrl_q.en && (tout_q == '1));
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned CW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic          frz_i,
  input  logic          tick_i,
  input  logic          load_i,
  input  logic [CW-1:0] tout_i,
  output logic          uflow_o
);
  logic [CW-1:0] cnt_q;
  logic          act_q;
  logic          step;

  // act_q lags enable by a cycle so the first count uses the fresh timeout
  assign step = act_q && tick_i && !frz_i && !load_i && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '1;
      act_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '1;
      act_q <= 1'b0;
    end else begin
      act_q <= en_i;
      if (!act_q || load_i) cnt_q <= tout_i;
      else if (step && (cnt_q != '0)) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign uflow_o = step && (cnt_q == '0);

  p_frz_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q && frz_i && !load_i && !clr_i |=> $stable(cnt_q));

  p_svc_reload_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && !clr_i |=> cnt_q == $past(tout_i));
endmodule

// File: rtl/wdog_rst_gen.sv
module wdog_rst_gen #(
  parameter int unsigned RST_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic uflow_i,
  output logic rst_o
);
  localparam int unsigned RW = $clog2(RST_CYCLES + 1);

  logic [RW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (uflow_i) cnt_q <= RW'(RST_CYCLES);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign rst_o = (cnt_q != '0);

  p_uflow_rst_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uflow_i |=> rst_o);

  // independent width counter for the pulse
  logic [RW:0] hi_len_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hi_len_q <= '0;
    else if (rst_o) hi_len_q <= hi_len_q + 1'b1;
    else hi_len_q <= '0;
  end

  p_pulse_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_o) |-> hi_len_q == (RW+1)'(RST_CYCLES));
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int unsigned CW         = 6,
  parameter int unsigned RST_CYCLES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              reg_we_i,
  input  logic              reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [1:0]        lpm_i,
  input  logic              debug_i,
  output logic              wdog_rst_o
);
  ctrl_t         ctrl;
  logic [CW-1:0] tout;
  logic          svc, uflow, frz, rst_pulse;

  wdog_regs #(.CW(CW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (rst_pulse),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_e'(reg_addr_i)),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .ctrl_o  (ctrl),
    .tout_o  (tout),
    .svc_o   (svc)
  );

  always_comb begin
    frz = debug_i && ctrl.dbg_frz;
    unique case (lpm_e'(lpm_i))
      LPM_DOZE: frz = frz || ctrl.doze_frz;
      LPM_STOP: frz = frz || ctrl.stop_frz;
      default:  ;
    endcase
  end

  wdog_counter #(.CW(CW)) u_counter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (rst_pulse),
    .en_i    (ctrl.en),
    .frz_i   (frz),
    .tick_i  (tick_i),
    .load_i  (svc),
    .tout_i  (tout),
    .uflow_o (uflow)
  );

  wdog_rst_gen #(.RST_CYCLES(RST_CYCLES)) u_rst_gen (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .uflow_i (uflow),
    .rst_o   (rst_pulse)
  );

  assign wdog_rst_o = rst_pulse;

  p_no_uflow_disabled_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl.en && !rst_pulse |=> !uflow);
endmodule

// File: tb/wdog_timer_bench.sv
module wdog_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RST_CYC = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        reg_we_i = 1'b0;
  logic        reg_addr_i = 1'b0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic [1:0]  lpm_i = 2'b00;
  logic        debug_i = 1'b0;
  logic        wdog_rst_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  wdog_timer u_wdog_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .lpm_i       (lpm_i),
    .debug_i     (debug_i),
    .wdog_rst_o  (wdog_rst_o)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  bit m_en, m_stp, m_dz, m_dbg, m_lock, m_armed, m_act;
  int m_to = 63, m_cnt = 63, m_rcnt = 0;

  function automatic void m_clear();
    m_en = 0; m_stp = 0; m_dz = 0; m_dbg = 0; m_lock = 0; m_armed = 0;
    m_act = 0; m_to = 63; m_cnt = 63;
  endfunction

  function automatic int m_rdata(bit a);
    if (a) return 0;
    return (m_to << 8) | (int'(m_dbg) << 3) | (int'(m_dz) << 2) | (int'(m_stp) << 1) | int'(m_en);
  endfunction

  always begin
    @(posedge clk_i);
    if (!rst_ni) begin
      m_clear(); m_rcnt = 0;
    end else if (m_rcnt != 0) begin
      m_clear(); m_rcnt--;
    end else begin
      bit frz, svc, uf;
      frz = (debug_i && m_dbg) || (lpm_i == 2'b10 && m_dz) || (lpm_i == 2'b11 && m_stp);
      svc = reg_we_i && reg_addr_i && reg_wdata_i == 16'hAAAA && m_armed;
      uf = m_act && tick_i && !frz && !svc && m_cnt == 0;
      if (!m_act || svc) m_cnt = m_to;
      else if (tick_i && !frz && m_cnt != 0) m_cnt--;
      m_act = m_en;
      if (reg_we_i && !reg_addr_i && !m_lock) begin
        m_en = reg_wdata_i[0]; m_stp = reg_wdata_i[1];
        m_dz = reg_wdata_i[2]; m_dbg = reg_wdata_i[3];
        m_to = int'(reg_wdata_i[13:8]); m_lock = 1;
      end
      if (reg_we_i && reg_addr_i) m_armed = (reg_wdata_i == 16'h5555);
      if (uf) m_rcnt = RST_CYC;
    end
    #2;
    chk(wdog_rst_o == (m_rcnt != 0), "R3", "model reset output", int'(wdog_rst_o), int'(m_rcnt != 0));
    chk(int'(reg_rdata_o) == m_rdata(reg_addr_i), "R5", "model readback", int'(reg_rdata_o), m_rdata(reg_addr_i));
  end

  task automatic wr(bit a, logic [15:0] d);
    @(negedge clk_i); reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i); reg_we_i = 0; reg_addr_i = 0;
  endtask

  task automatic rd_chk(bit a, int exp, string req);
    @(negedge clk_i); reg_addr_i = a; #1;
    chk(int'(reg_rdata_o) == exp, req, "readback", int'(reg_rdata_o), exp);
    @(negedge clk_i); reg_addr_i = 0;
  endtask

  task automatic ticks(int n);
    repeat (n) begin
      @(negedge clk_i); tick_i = 1;
      @(negedge clk_i); tick_i = 0;
    end
  endtask

  task automatic service();
    wr(1, 16'h5555); wr(1, 16'hAAAA);
  endtask

  task automatic pulse_len_chk();
    int len = 0;
    while (wdog_rst_o) begin len++; @(negedge clk_i); end
    chk(len == RST_CYC, "R4", "reset pulse length", len, RST_CYC);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk(wdog_rst_o == 0, "R1", "reset output after reset", int'(wdog_rst_o), 0);
    rd_chk(0, 16'h3F00, "R1");
    rd_chk(1, 0, "R13");
    ticks(70);
    chk(wdog_rst_o == 0, "R2", "no reset while disabled", int'(wdog_rst_o), 0);
    // T=3, enable, doze freeze
    wr(0, 16'h0305);
    rd_chk(0, 16'h0305, "R5");
    wr(0, 16'h0A0F);
    rd_chk(0, 16'h0305, "R5");
    service();
    ticks(3);
    chk(wdog_rst_o == 0, "R7", "no reset after T ticks", int'(wdog_rst_o), 0);
    service();
    ticks(3);
    chk(wdog_rst_o == 0, "R7", "service reloaded counter", int'(wdog_rst_o), 0);
    lpm_i = 2'b10;
    ticks(5);
    chk(wdog_rst_o == 0, "R9", "doze freeze", int'(wdog_rst_o), 0);
    lpm_i = 2'b00;
    wr(1, 16'h5555); wr(1, 16'h1234); wr(1, 16'hAAAA);
    rd_chk(1, 0, "R13");
    ticks(1);
    chk(wdog_rst_o == 1, "R8", "broken sequence gave no reload", int'(wdog_rst_o), 1);
    pulse_len_chk();
    rd_chk(0, 16'h3F00, "R6");
    // T=2, enable, stop and debug freeze
    wr(0, 16'h020B);
    rd_chk(0, 16'h020B, "R6");
    service();
    lpm_i = 2'b11;
    ticks(6);
    chk(wdog_rst_o == 0, "R10", "stop freeze", int'(wdog_rst_o), 0);
    lpm_i = 2'b00; debug_i = 1;
    ticks(6);
    chk(wdog_rst_o == 0, "R11", "debug freeze", int'(wdog_rst_o), 0);
    debug_i = 0;
    lpm_i = 2'b10;
    ticks(2);
    chk(wdog_rst_o == 0, "R3", "no reset after T ticks", int'(wdog_rst_o), 0);
    ticks(1);
    chk(wdog_rst_o == 1, "R12", "doze with bit clear counts to underflow", int'(wdog_rst_o), 1);
    pulse_len_chk();
    lpm_i = 2'b00;
    // T=1, enable only, wait mode
    wr(0, 16'h0101);
    service();
    lpm_i = 2'b01;
    ticks(1);
    chk(wdog_rst_o == 0, "R3", "no reset after T ticks", int'(wdog_rst_o), 0);
    ticks(1);
    chk(wdog_rst_o == 1, "R12", "wait mode counts to underflow", int'(wdog_rst_o), 1);
    pulse_len_chk();
    lpm_i = 2'b00;
    rd_chk(0, 16'h3F00, "R6");
    repeat (4) @(negedge clk_i);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R3 watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule